// File: doc/BRIEF.md
# Cumulative DRAM Row Boundary Decoder

This block finds which DRAM row holds a physical address. It keeps eight 8-bit boundary registers. Software programs each one with the running total of installed memory, counted in 8 MB steps: register n holds the size of rows 0 through n together. A row therefore starts where the previous row's total ends and stops at its own total. Row 0 starts at zero. A row whose total equals the total before it holds no memory and is skipped.

A host presents an address with a valid strobe. One clock later the block returns the matching row as a binary index and as a one-hot chip-select. If the address lies at or beyond the last total, it raises a miss flag instead. The block also drives the top of installed memory in bytes. The registers are written and read through a byte-wide configuration port. Each row is 64 bits wide. Column and bank splitting and DRAM command timing belong to other blocks.

Top module: `dram_row_decoder`

## Requirements
- R1: After reset, every boundary register reads 01h, the decode outputs (dec_valid, dec_cs, dec_miss, dec_row) are zero, and top_of_mem is 0x0080_0000.
- R2: A write with cfg_wr high at offset 60h+n (n = 0..7) loads boundary register n. cfg_rdata is registered: it shows the register at the offset sampled on the previous clock edge.
- R3: Writes to offsets outside 60h..67h change no register and do not change top_of_mem. Reads from those offsets return 00h.
- R4: For a request, dec_row is the lowest n for which req_addr[31:23] is less than register n. The comparison is unsigned, and register n is zero-extended to 9 bits.
- R5: On a hit, dec_cs has exactly one bit set, and that bit is bit dec_row.
- R6: When req_addr[31:23] is greater than or equal to register 7, dec_miss is 1, dec_cs is zero and dec_row is 0.
- R7: A row whose register is not greater than the register of the row before it is never selected.
- R8: dec_valid, dec_row, dec_cs and dec_miss reflect a request one clock after req_valid. In a cycle that follows no request, dec_valid, dec_cs and dec_miss are zero.
- R9: top_of_mem equals register 7 shifted left by 23. It follows a write to offset 67h from the next clock on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Registered read data for the offset on the previous clock |
| req_valid | input | 1 | Address request strobe |
| req_addr | input | 32 | Physical byte address to decode |
| dec_valid | output | 1 | Decode result valid, one clock after req_valid |
| dec_row | output | 3 | Selected row index |
| dec_cs | output | 8 | One-hot row chip-select |
| dec_miss | output | 1 | Address at or beyond top of memory |
| top_of_mem | output | 32 | Top of installed memory in bytes |

## Verification
Some properties are checked on every clock. These are the one-cycle latency of the result, the single chip-select matching the row index on a hit, and a quiet output when no request was made. The miss flag is compared with the top_of_mem port for every request. top_of_mem is also checked to stay unchanged after a write to an unmapped offset. Other behaviour can only be shown by the bench's scenarios. This covers the choice of the lowest qualifying row, the skipping of empty rows at several places in the map, the exact edges of each row, the reset values and readback. The bench runs a sparse map with three empty rows, the all-default map, and a full-size top row.

// File: rtl/drd_pkg.sv
package drd_pkg;
  localparam int CFG_AW = 8;
  localparam int CFG_DW = 8;

  typedef struct packed {
    logic              wr;
    logic [CFG_AW-1:0] addr;
    logic [CFG_DW-1:0] data;
  } cfg_cmd_t;
endpackage

// File: rtl/drd_bound_regs.sv
module drd_bound_regs
  import drd_pkg::*;
#(
  parameter int ROWS     = 8,
  parameter int BND_W    = 8,
  parameter int CFG_BASE = 8'h60,
  parameter int RST_VAL  = 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  cfg_cmd_t              cmd,
  output logic [CFG_DW-1:0]     rdata,
  output logic [ROWS*BND_W-1:0] bounds
);
  localparam int IDX_W = (ROWS > 1) ? $clog2(ROWS) : 1;

  logic [CFG_AW-1:0] rel;
  logic              in_rng;
  logic [IDX_W-1:0]  idx;

  assign rel    = cmd.addr - CFG_AW'(CFG_BASE);
  assign in_rng = (rel < CFG_AW'(ROWS));
  assign idx    = rel[IDX_W-1:0];

  for (genvar g = 0; g < ROWS; g++) begin : g_reg
    logic [BND_W-1:0] val;
    always_ff @(posedge clk) begin
      if (rst)
        val <= BND_W'(RST_VAL);
      else if (cmd.wr && in_rng && (idx == IDX_W'(g)))
        val <= cmd.data[BND_W-1:0];
    end
    assign bounds[g*BND_W +: BND_W] = val;
  end

  always_ff @(posedge clk) begin
    if (rst)
      rdata <= '0;
    else if (in_rng)
      rdata <= CFG_DW'(bounds[idx*BND_W +: BND_W]);
    else
      rdata <= '0;
  end
endmodule

// File: rtl/drd_row_match.sv
module drd_row_match #(
  parameter int ROWS  = 8,
  parameter int BND_W = 8,
  parameter int FLD_W = 9,
  localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic [FLD_W-1:0]      field,
  input  logic [ROWS*BND_W-1:0] bounds,
  output logic                  hit,
  output logic [ROW_W-1:0]      row,
  output logic [ROWS-1:0]       cs
);
  logic [ROWS-1:0] below;

  for (genvar g = 0; g < ROWS; g++) begin : g_cmp
    assign below[g] = field < FLD_W'(bounds[g*BND_W +: BND_W]);
  end

  always_comb begin
    row = '0;
    cs  = '0;
    hit = |below;
    for (int i = ROWS - 1; i >= 0; i--) begin
      if (below[i]) begin
        row = ROW_W'(i);
        cs  = ROWS'(1) << i;
      end
    end
  end
endmodule

// File: rtl/dram_row_decoder.sv
module dram_row_decoder
  import drd_pkg::*;
#(
  parameter int ROWS       = 8,
  parameter int BND_W      = 8,
  parameter int ADDR_W     = 32,
  parameter int UNIT_SHIFT = 23,
  parameter int CFG_BASE   = 8'h60,
  parameter int RST_VAL    = 1,
  localparam int ROW_W     = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int FLD_W     = ADDR_W - UNIT_SHIFT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic [7:0]        cfg_addr,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              dec_valid,
  output logic [ROW_W-1:0]  dec_row,
  output logic [ROWS-1:0]   dec_cs,
  output logic              dec_miss,
  output logic [ADDR_W-1:0] top_of_mem
);
  cfg_cmd_t              cmd;
  logic [ROWS*BND_W-1:0] bounds;
  logic                  m_hit;
  logic [ROW_W-1:0]      m_row;
  logic [ROWS-1:0]       m_cs;
  logic                  unused_low_bits;

  assign cmd = '{wr: cfg_wr, addr: cfg_addr, data: cfg_wdata};
  assign unused_low_bits = ^req_addr[UNIT_SHIFT-1:0];

  drd_bound_regs #(
    .ROWS(ROWS), .BND_W(BND_W), .CFG_BASE(CFG_BASE), .RST_VAL(RST_VAL)
  ) regs_i (
    .clk(clk), .rst(rst), .cmd(cmd), .rdata(cfg_rdata), .bounds(bounds)
  );

  drd_row_match #(
    .ROWS(ROWS), .BND_W(BND_W), .FLD_W(FLD_W)
  ) match_i (
    .field(req_addr[ADDR_W-1:UNIT_SHIFT]), .bounds(bounds),
    .hit(m_hit), .row(m_row), .cs(m_cs)
  );

  assign top_of_mem = ADDR_W'(bounds[(ROWS-1)*BND_W +: BND_W]) << UNIT_SHIFT;

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_valid <= 1'b0;
      dec_row   <= '0;
      dec_cs    <= '0;
      dec_miss  <= 1'b0;
    end else begin
      dec_valid <= req_valid;
      dec_row   <= (req_valid && m_hit) ? m_row : '0;
      dec_cs    <= (req_valid && m_hit) ? m_cs : '0;
      dec_miss  <= req_valid && !m_hit;
    end
  end
endmodule

// File: rtl/drd_checker.sv
module drd_checker #(
  parameter int ROWS     = 8,
  parameter int ADDR_W   = 32,
  parameter int CFG_BASE = 8'h60,
  localparam int ROW_W   = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_wr,
  input logic [7:0]        cfg_addr,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_addr,
  input logic              dec_valid,
  input logic [ROW_W-1:0]  dec_row,
  input logic [ROWS-1:0]   dec_cs,
  input logic              dec_miss,
  input logic [ADDR_W-1:0] top_of_mem
);
  logic oob_wr;
  assign oob_wr = cfg_wr && ((int'(cfg_addr) < CFG_BASE) ||
                             (int'(cfg_addr) >= CFG_BASE + ROWS));

  p_valid_follows_r8: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> dec_valid);
  p_idle_follows_r8: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!dec_valid && dec_cs == '0 && !dec_miss));
  p_single_cs_r5: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && !dec_miss) |-> ($countones(dec_cs) == 1 && dec_cs[dec_row]));
  p_miss_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    dec_miss |-> (dec_cs == '0 && dec_row == '0));
  p_miss_above_top_r6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_addr >= top_of_mem) |=> dec_miss);
  p_hit_below_top_r4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_addr < top_of_mem) |=> !dec_miss);
  p_oob_write_r3: assert property (@(posedge clk) disable iff (rst)
    oob_wr |=> $stable(top_of_mem));
endmodule

bind dram_row_decoder drd_checker #(
  .ROWS(ROWS), .ADDR_W(ADDR_W), .CFG_BASE(CFG_BASE)
) chk_i (
  .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
  .req_valid(req_valid), .req_addr(req_addr), .dec_valid(dec_valid),
  .dec_row(dec_row), .dec_cs(dec_cs), .dec_miss(dec_miss),
  .top_of_mem(top_of_mem)
);

// File: tb/dram_row_decoder_tb.sv
module dram_row_decoder_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 12;
  // {addr[31:0], miss, row[2:0]} with map 2,2,6,6,8,16,16,32 (8 MB units)
  localparam logic [35:0] VEC [NVEC] = '{
    {32'h0000_0000, 1'b0, 3'd0}, {32'h00FF_FFFF, 1'b0, 3'd0},
    {32'h0100_0000, 1'b0, 3'd2}, {32'h02FF_FFFF, 1'b0, 3'd2},
    {32'h0300_0000, 1'b0, 3'd4}, {32'h03FF_FFFF, 1'b0, 3'd4},
    {32'h0400_0000, 1'b0, 3'd5}, {32'h07FF_FFFF, 1'b0, 3'd5},
    {32'h0800_0000, 1'b0, 3'd7}, {32'h0FFF_FFFF, 1'b0, 3'd7},
    {32'h1000_0000, 1'b1, 3'd0}, {32'h8000_0000, 1'b1, 3'd0}
  };
  localparam logic [7:0] MAP [8] = '{8'd2, 8'd2, 8'd6, 8'd6, 8'd8, 8'd16, 8'd16, 8'd32};

  logic clk = 0, rst = 1;
  logic cfg_wr = 0;
  logic [7:0] cfg_addr = 0, cfg_wdata = 0, cfg_rdata;
  logic req_valid = 0;
  logic [31:0] req_addr = 0, top_of_mem;
  logic dec_valid, dec_miss;
  logic [2:0] dec_row;
  logic [7:0] dec_cs;
  int nchk = 0, nfail = 0, cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dram_row_decoder dut_i (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
    .req_addr(req_addr), .dec_valid(dec_valid), .dec_row(dec_row),
    .dec_cs(dec_cs), .dec_miss(dec_miss), .top_of_mem(top_of_mem)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      nfail++;
      $display("FAIL watchdog: run hung, act=%0d exp<=20000", cycles);
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] off, input logic [7:0] d);
    @(negedge clk); cfg_wr = 1; cfg_addr = off; cfg_wdata = d;
    @(negedge clk); cfg_wr = 0;
  endtask

  task automatic rd(input logic [7:0] off, output logic [7:0] d);
    @(negedge clk); cfg_addr = off;
    @(negedge clk); d = cfg_rdata;
  endtask

  task automatic dec(input logic [31:0] a, input string req, input logic miss, input logic [2:0] row);
    @(negedge clk); req_valid = 1; req_addr = a;
    @(negedge clk); req_valid = 0;
    check(req, {dec_valid, dec_miss, dec_row, dec_cs},
          {1'b1, miss, (miss ? 3'd0 : row), (miss ? 8'h00 : (8'h01 << row))});
  endtask

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset state
    check("R1 outputs", {dec_valid, dec_miss, dec_row, dec_cs}, 0);
    check("R1 top_of_mem", top_of_mem, 32'h0080_0000);
    for (int i = 0; i < 8; i++) begin
      rd(8'h60 + 8'(i), d);
      check("R1 reset reg", d, 8'h01);
    end
    // R4 R7: default map, rows 1..7 empty
    dec(32'h0000_0000, "R4 default row0", 0, 0);
    dec(32'h0080_0000, "R7 default empties miss", 1, 0);
    // R8: idle cycle after request
    @(negedge clk);
    check("R8 idle", {dec_valid, dec_miss, dec_cs}, 0);
    // R2: program map and read back
    for (int i = 0; i < 8; i++) wr(8'h60 + 8'(i), MAP[i]);
    for (int i = 0; i < 8; i++) begin
      rd(8'h60 + 8'(i), d);
      check("R2 readback", d, MAP[i]);
    end
    check("R9 top_of_mem", top_of_mem, 32'h1000_0000);
    // R4 R5 R6 R7: vector table
    for (int v = 0; v < NVEC; v++)
      dec(VEC[v][35:4], "R4/R5/R6/R7 vector", VEC[v][3], VEC[v][2:0]);
    // R3: out-of-range writes and reads
    wr(8'h68, 8'hAA);
    wr(8'h5F, 8'h55);
    check("R3 top unchanged", top_of_mem, 32'h1000_0000);
    for (int i = 0; i < 8; i++) begin
      rd(8'h60 + 8'(i), d);
      check("R3 regs unchanged", d, MAP[i]);
    end
    rd(8'h68, d); check("R3 read 68h", d, 8'h00);
    rd(8'h5F, d); check("R3 read 5Fh", d, 8'h00);
    // R9: maximum top row
    wr(8'h67, 8'hFF);
    check("R9 top max", top_of_mem, 32'h7F80_0000);
    dec(32'h7F7F_FFFF, "R6 just below top", 0, 7);
    dec(32'h7F80_0000, "R6 at top", 1, 0);
    // R8: back-to-back requests
    @(negedge clk); req_valid = 1; req_addr = 32'h0000_0000;
    @(negedge clk); req_addr = 32'h0300_0000;
    check("R8 b2b first", {dec_valid, dec_row}, {1'b1, 3'd0});
    @(negedge clk); req_valid = 0;
    check("R8 b2b second", {dec_valid, dec_row}, {1'b1, 3'd4});
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule